// File: doc/BRIEF.md
# Receive Byte Queue with Idle Timeout

This block is the receive-side buffer of a 16550-style serial port. Bytes from the deserialiser enter with a valid strobe. A break event enters as a zero byte. The host drains the buffer through a read strobe, and the read byte appears on `rd_data` one cycle later. A configuration write chooses between two modes: a single holding register, or a 16-deep queue. The same write sets the trigger level and can empty the queue. The block produces the line-status bits for the receive path: data ready, overrun and break. It also produces a trigger-reached flag and a timeout flag.

In queue mode an idle timer watches the queue. It fires when the queue holds data but has seen neither an arrival nor a read for four character times. One character time is computed from the frame-format field and the baud divisor, at sixteen clocks per bit. When the queue is full, incoming bytes are dropped. The stored bytes are kept, and the overrun bit records the loss.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, the block is in holding-register mode with trigger selection 0. `fill_count`, `data_ready`, `overrun`, `brk_flag`, `trig_hit`, `tmo_pending` and `rd_data` are all 0.
- R2: In queue mode, bytes are returned in arrival order. Each byte is on `rd_data` in the cycle after its `rd_strobe`. `fill_count` follows pushes and pops.
- R3: In queue mode, `data_ready` is 1 exactly when the queue holds data. A read that empties the queue clears it. A read of an empty queue returns 0x00.
- R4: When the queue holds 16 bytes, a new byte is discarded and `overrun` is set. The 16 stored bytes are unchanged and are read out intact.
- R5: `cfg_data[7:6]` selects the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode, `trig_hit` is 1 when `fill_count` is at or above the level. In holding-register mode, `trig_hit` equals `data_ready`. A configuration write that neither flushes nor toggles the mode keeps the stored data.
- R6: In queue mode, `tmo_pending` rises exactly 64 x frame bits x `divisor` cycles after the last arrival, or after the last read that left data. The count runs only while the queue holds data. A read clears the flag and restarts the count. A divisor of 0 disables the timer.
- R7: Frame bits are 1 start bit, plus 5 + `frame_cfg[1:0]` data bits, plus 1 if `frame_cfg[3]` (parity) is set, plus 2 stop bits if `frame_cfg[2]` is set or 1 stop bit if it is clear.
- R8: Some configuration writes flush the queue: a write with `cfg_data[1]` set, or a write whose `cfg_data[0]` differs from the current mode (1 = queue mode). A flush empties the queue and clears `data_ready`, `brk_flag` and `tmo_pending`, but leaves `overrun` as it is. A byte that arrives in the same cycle as a flush is dropped.
- R9: `rx_break` stores a 0x00 byte and sets both `brk_flag` and `data_ready`. It takes precedence over `rx_valid` in the same cycle.
- R10: In holding-register mode, a byte that arrives while `data_ready` is set overwrites the held byte and sets `overrun`. A read returns the held byte and clears `data_ready`. `fill_count` stays 0 in this mode.
- R11: `lsr_rd` clears `overrun` and `brk_flag`. If a new overrun or break occurs in the same cycle, the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break condition seen on the line |
| rd_strobe | input | 1 | Receive data read |
| lsr_rd | input | 1 | Line status read (clears overrun and break) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration value: [0] queue mode, [1] flush, [7:6] trigger select |
| frame_cfg | input | 4 | Frame format: [1:0] data length, [2] two stop bits, [3] parity |
| divisor | input | 16 | Baud divisor (bit time = divisor x 16 clocks) |
| rd_data | output | 8 | Byte returned by the last read |
| fill_count | output | 5 | Bytes held in the queue |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | Byte lost |
| brk_flag | output | 1 | Break received |
| trig_hit | output | 1 | Trigger level reached |
| tmo_pending | output | 1 | Character timeout pending |

## Verification
The hardest state to reach is the idle timeout. It needs a queue holding data, a frame format and divisor that have settled into the computed limit, and then an exact run of quiet cycles. The stimulus sets a small divisor and three different frame formats. For each, it samples `tmo_pending` one cycle before and exactly at the expected edge. One of these runs is measured from a read that leaves data behind, which checks that a read restarts the count. Full-queue overrun is reached by raising the trigger to 14 and pushing 17 bytes, and the scoreboard then confirms that the first 16 bytes come out unchanged.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Bits in one serial character: start + data + optional parity + stop.
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    logic [3:0] n;
    n = 4'd1 + 4'd5 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]};
    n = n + (fmt[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || do_pop);

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1);
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int CW = 5
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] lvl
);
  always_comb begin
    case (sel)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       frame_cfg,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  input  logic             active,
  output logic             expire
);
  import rxq_pkg::*;

  // 4 chars x 16 clocks per bit = 64 clocks per frame bit.
  localparam int LIM_W = DIV_W + 10;

  logic [LIM_W-1:0] limit_q, cnt_q;
  logic             at_end;

  assign at_end = (limit_q != '0) && (cnt_q >= limit_q - LIM_W'(1));
  assign expire = active && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
    end else begin
      limit_q <= (LIM_W'(frame_bits(frame_cfg)) * LIM_W'(divisor)) << 6;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt_q <= '0;
    end else if (!at_end && (cnt_q != '1)) begin
      cnt_q <= cnt_q + LIM_W'(1);
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int DIV_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_valid,
  input  logic [W-1:0]               rx_byte,
  input  logic                       rx_break,
  input  logic                       rd_strobe,
  input  logic                       lsr_rd,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_data,
  input  logic [3:0]                 frame_cfg,
  input  logic [DIV_W-1:0]           divisor,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       data_ready,
  output logic                       overrun,
  output logic                       brk_flag,
  output logic                       trig_hit,
  output logic                       tmo_pending
);
  localparam int CW = $clog2(DEPTH+1);

  logic          fifo_en_q;
  logic [1:0]    lvl_sel_q;
  logic [W-1:0]  hold_q, rd_data_q;
  logic          dr_q, ovr_q, brk_q, tmo_q;
  logic          dr_n, ovr_n, brk_n, tmo_n;

  logic [W-1:0]  head;
  logic [CW-1:0] cnt, lvl;
  logic          full, empty, expire;

  logic          flush, any_in, f_rd, f_pop, f_push_req, f_push, f_drop, leaves_empty;
  logic [W-1:0]  in_byte;

  assign flush        = cfg_wr && (cfg_data[1] || (cfg_data[0] != fifo_en_q));
  assign any_in       = rx_valid || rx_break;
  assign in_byte      = rx_break ? '0 : rx_byte;
  assign f_rd         = fifo_en_q && rd_strobe && !flush;
  assign f_pop        = f_rd && !empty;
  assign f_push_req   = fifo_en_q && any_in && !flush;
  assign f_push       = f_push_req && (!full || f_pop);
  assign f_drop       = f_push_req && full && !f_pop;
  assign leaves_empty = f_pop && (cnt == CW'(1)) && !f_push;

  rxq_ring #(.DEPTH(DEPTH), .W(W)) ring_i (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (f_push),
    .pop   (f_pop),
    .din   (in_byte),
    .head  (head),
    .count (cnt),
    .full  (full),
    .empty (empty)
  );

  rxq_level #(.CW(CW)) level_i (
    .sel (lvl_sel_q),
    .lvl (lvl)
  );

  rxq_idle_timer #(.DIV_W(DIV_W)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .frame_cfg (frame_cfg),
    .divisor   (divisor),
    .restart   (f_push_req || f_rd || flush),
    .active    (fifo_en_q && !empty),
    .expire    (expire)
  );

  // Next-state for the status bits; later statements take priority.
  always_comb begin
    dr_n  = dr_q;
    ovr_n = ovr_q;
    brk_n = brk_q;
    tmo_n = tmo_q;
    if (lsr_rd) begin
      ovr_n = 1'b0;
      brk_n = 1'b0;
    end
    if (flush) begin
      dr_n  = 1'b0;
      brk_n = 1'b0;
      tmo_n = 1'b0;
    end else if (fifo_en_q) begin
      if (f_rd) tmo_n = 1'b0;
      if (leaves_empty) begin
        dr_n  = 1'b0;
        brk_n = 1'b0;
      end
      if (f_push) dr_n = 1'b1;
      if (f_push_req && rx_break) brk_n = 1'b1;
      if (f_drop) ovr_n = 1'b1;
      if (expire && !f_rd) tmo_n = 1'b1;
    end else begin
      tmo_n = 1'b0;
      if (rd_strobe) begin
        dr_n  = 1'b0;
        brk_n = 1'b0;
      end
      if (any_in) begin
        if (dr_q && !rd_strobe) ovr_n = 1'b1;
        dr_n = 1'b1;
        if (rx_break) brk_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= 1'b0;
      lvl_sel_q <= '0;
      hold_q    <= '0;
      rd_data_q <= '0;
      dr_q      <= 1'b0;
      ovr_q     <= 1'b0;
      brk_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      if (cfg_wr) begin
        fifo_en_q <= cfg_data[0];
        lvl_sel_q <= cfg_data[7:6];
      end
      if (!fifo_en_q && any_in && !flush) hold_q <= in_byte;
      if (rd_strobe && !flush) rd_data_q <= fifo_en_q ? (empty ? '0 : head) : hold_q;
      dr_q  <= dr_n;
      ovr_q <= ovr_n;
      brk_q <= brk_n;
      tmo_q <= tmo_n;
    end
  end

  assign rd_data     = rd_data_q;
  assign fill_count  = cnt;
  assign data_ready  = dr_q;
  assign overrun     = ovr_q;
  assign brk_flag    = brk_q;
  assign tmo_pending = tmo_q;
  assign trig_hit    = fifo_en_q ? (cnt >= lvl) : dr_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_strobe,
  input logic          lsr_rd,
  input logic          cfg_wr,
  input logic [7:0]    cfg_data,
  input logic [CW-1:0] fill_count,
  input logic          data_ready,
  input logic          overrun,
  input logic          brk_flag,
  input logic          tmo_pending
);
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(DEPTH));

  p_full_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_en && (fill_count == CW'(DEPTH)) && rx_valid && !rd_strobe && !cfg_wr
    |=> overrun && (fill_count == CW'(DEPTH)));

  p_ready_tracks_fill_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_en |-> ((fill_count == '0) == !data_ready));

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_data[1]
    |=> (fill_count == '0) && !data_ready && !tmo_pending && !brk_flag);

  p_tmo_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    tmo_pending |-> (fill_count != '0));

  p_read_clears_tmo_r6: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !tmo_pending);

  p_lsr_clear_r11: assert property (@(posedge clk) disable iff (rst)
    lsr_rd && !rx_valid && !rx_break |=> !overrun && !brk_flag);

  p_break_r9: assert property (@(posedge clk) disable iff (rst)
    rx_break && !cfg_wr |=> brk_flag && data_ready);

  p_hold_mode_empty_r10: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (fill_count == '0));
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fifo_en     (fifo_en_q),
  .rx_valid    (rx_valid),
  .rx_break    (rx_break),
  .rd_strobe   (rd_strobe),
  .lsr_rd      (lsr_rd),
  .cfg_wr      (cfg_wr),
  .cfg_data    (cfg_data),
  .fill_count  (fill_count),
  .data_ready  (data_ready),
  .overrun     (overrun),
  .brk_flag    (brk_flag),
  .tmo_pending (tmo_pending)
);

// File: tb/rx_byte_queue_tb_top.sv
`timescale 1ns/1ps
module rx_byte_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rd_strobe = 1'b0, lsr_rd = 1'b0, cfg_wr = 1'b0;
  logic [7:0]  rx_byte = '0, cfg_data = '0;
  logic [3:0]  frame_cfg = 4'b0011;
  logic [15:0] divisor = 16'd1;
  logic [7:0]  rd_data;
  logic [4:0]  fill_count;
  logic        data_ready, overrun, brk_flag, trig_hit, tmo_pending;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] hold_m = '0;
  bit         fifo_m = 1'b0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_byte_queue dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rd_strobe(rd_strobe), .lsr_rd(lsr_rd), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .frame_cfg(frame_cfg), .divisor(divisor), .rd_data(rd_data), .fill_count(fill_count),
    .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag), .trig_hit(trig_hit),
    .tmo_pending(tmo_pending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Driver tasks: drive at negedge, update the reference model.
  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    if (fifo_m) begin
      if (model_q.size() < 16) model_q.push_back(b);
    end else hold_m = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk_in();
    rx_break = 1'b1;
    if (fifo_m) begin
      if (model_q.size() < 16) model_q.push_back(8'h00);
    end else hold_m = 8'h00;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic rd();
    logic [7:0] e;
    if (fifo_m) e = (model_q.size() != 0) ? model_q.pop_front() : 8'h00;
    else e = hold_m;
    exp_q.push_back(e);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic fcr(input logic [7:0] v);
    if (v[1] || (v[0] != fifo_m)) model_q.delete();
    fifo_m = v[0];
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic lsr();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  // Called right after the event that (re)starts the idle count.
  task automatic tmo_window(input int limit, input string tag);
    repeat (limit - 1) @(negedge clk);
    chk_eq({tag, " before limit"}, tmo_pending, 0);
    @(negedge clk);
    chk_eq({tag, " at limit"}, tmo_pending, 1);
  endtask

  // Monitor: compare each read result with the scoreboard.
  always @(posedge clk) begin
    if (!rst && rd_strobe) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", rd_data, -1);
      else chk_eq("R2 read data", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 fill", fill_count, 0);
    chk_eq("R1 ready", data_ready, 0);
    chk_eq("R1 overrun", overrun, 0);
    chk_eq("R1 break", brk_flag, 0);
    chk_eq("R1 trig", trig_hit, 0);
    chk_eq("R1 tmo", tmo_pending, 0);
    chk_eq("R1 rd_data", rd_data, 0);

    // R10 holding-register mode
    send(8'hA5);
    chk_eq("R10 ready", data_ready, 1);
    chk_eq("R5 trig follows ready", trig_hit, 1);
    chk_eq("R10 fill stays 0", fill_count, 0);
    send(8'h3C);
    chk_eq("R10 overrun", overrun, 1);
    rd();
    chk_eq("R10 ready cleared", data_ready, 0);
    lsr();
    chk_eq("R11 overrun cleared", overrun, 0);

    // R2/R3 queue mode order
    fcr(8'h01);
    chk_eq("R8 toggle clears ready", data_ready, 0);
    send(8'h11); send(8'h22); send(8'h33);
    chk_eq("R2 fill", fill_count, 3);
    chk_eq("R5 level1 trig", trig_hit, 1);
    rd(); rd();
    chk_eq("R3 ready with data", data_ready, 1);
    rd();
    chk_eq("R3 ready after empty", data_ready, 0);
    rd(); // R3 empty read returns 0

    // R5 trigger levels
    fcr(8'h41);
    send(8'h01); send(8'h02); send(8'h03);
    chk_eq("R5 level4 below", trig_hit, 0);
    send(8'h04);
    chk_eq("R5 level4 reached", trig_hit, 1);
    fcr(8'h81);
    chk_eq("R5 level8 below", trig_hit, 0);
    chk_eq("R5 no flush on level change", fill_count, 4);
    fcr(8'hC1);
    for (int i = 5; i <= 13; i++) send(8'(i));
    chk_eq("R5 level14 below", trig_hit, 0);
    send(8'd14);
    chk_eq("R5 level14 reached", trig_hit, 1);
    send(8'd15); send(8'd16);
    chk_eq("R4 full", fill_count, 16);
    chk_eq("R4 no overrun yet", overrun, 0);
    send(8'hEE);
    chk_eq("R4 overrun", overrun, 1);
    chk_eq("R4 fill kept", fill_count, 16);
    lsr();
    chk_eq("R11 overrun cleared fifo", overrun, 0);
    for (int i = 0; i < 16; i++) rd();
    chk_eq("R3 drained", data_ready, 0);

    // R9 break
    brk_in();
    chk_eq("R9 break flag", brk_flag, 1);
    chk_eq("R9 ready", data_ready, 1);
    chk_eq("R9 fill", fill_count, 1);
    rd();
    chk_eq("R9 break cleared by draining read", brk_flag, 0);
    brk_in();
    lsr();
    chk_eq("R11 break cleared by status read", brk_flag, 0);
    chk_eq("R11 ready kept", data_ready, 1);

    // R8 flush
    send(8'h55);
    fcr(8'h03);
    chk_eq("R8 flush fill", fill_count, 0);
    chk_eq("R8 flush ready", data_ready, 0);

    // R6/R7 timeout, 8 data 1 stop no parity: 10 bits
    frame_cfg = 4'b0011; divisor = 16'd1;
    repeat (3) @(negedge clk);
    send(8'hA1);
    send(8'hA2);
    tmo_window(640, "R7 10-bit frame R6");
    rd();
    chk_eq("R6 read clears tmo", tmo_pending, 0);
    tmo_window(640, "R6 restart on read");
    rd();
    chk_eq("R6 empty no tmo", tmo_pending, 0);

    // R7: 8 data, parity, 2 stop = 12 bits
    frame_cfg = 4'b1111;
    repeat (3) @(negedge clk);
    send(8'hB1);
    tmo_window(768, "R7 12-bit frame");
    fcr(8'h03);
    chk_eq("R8 flush clears tmo", tmo_pending, 0);

    // R7: 5 data, 1 stop = 7 bits, divisor 2
    frame_cfg = 4'b0000; divisor = 16'd2;
    repeat (3) @(negedge clk);
    send(8'hC1);
    tmo_window(896, "R7 7-bit frame div2");
    rd();

    // R6 divisor 0 disables
    divisor = 16'd0;
    repeat (3) @(negedge clk);
    send(8'hD1);
    repeat (2000) @(negedge clk);
    chk_eq("R6 divisor 0 no tmo", tmo_pending, 0);

    // R8 toggle back to holding mode flushes
    send(8'hD2);
    fcr(8'h00);
    chk_eq("R8 mode toggle flush", fill_count, 0);
    chk_eq("R8 mode toggle ready", data_ready, 0);

    repeat (3) @(negedge clk);
    chk_eq("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule